// File: doc/BRIEF.md
# Three-Bit-Spaced Preamble Detector

This block sits on the read side of a run-length-limited channel. It takes one code bit per clock. While the read gate is high, it looks for a preamble made of code pulses, where each pulse is a one followed by exactly two zeros. It counts an uninterrupted run of such pulses. When the run reaches sixteen pulses, it raises a preamble-found flag and emits a one-cycle sync-start pulse. Downstream logic uses that pulse to reset its decode state machine and to begin phase synchronization.

Any disturbance in the spacing ends the run:

- A pulse that arrives too early, after zero or one zeros, starts a new run of length one.
- A third consecutive zero also ends the run. The detector then waits for the next pulse.

Once the flag is up, it stays up until the read gate falls. Dropping the read gate clears everything.

The control is a five-state machine:

| State | Meaning | Transitions |
|---|---|---|
| IDLE | Gate low | To TRACK on a gated pulse, to HUNT on a gated zero |
| HUNT | Gate high, no pulse yet | To TRACK on a pulse |
| TRACK | Run in progress | A well-spaced pulse extends the run. A badly spaced pulse restarts it at one. A third zero returns to HUNT. The sixteenth well-spaced pulse goes to SYNC |
| SYNC | One cycle, sync-start high | Always to LOCKED |
| LOCKED | Flag held | Stays until the gate falls |

A low gate sends every state to IDLE.

Top module: `preamble3t_det`

## Requirements
- R1: While rst_n is low, and on the first cycle after reset, pre_found and sync_start are 0.
- R2: A sample taken while rd_gate is 0 is ignored. One clock after an edge that samples rd_gate low, pre_found and sync_start are 0.
- R3: A pulse is code_bit=1, and well-spaced means exactly two 0 samples lie between consecutive pulses. When the edge samples the sixteenth pulse of an unbroken, well-spaced run, pre_found reads 1 right after that edge.
- R4: A run of fifteen well-spaced pulses does not raise pre_found.
- R5: A pulse that follows the previous pulse after exactly one 0 breaks the run and counts as pulse one of a new run.
- R6: Three consecutive 0 samples after a pulse clear the run. The next pulse is pulse one of a new run.
- R7: sync_start is 1 for exactly the one cycle in which pre_found first reads 1.
- R8: While rd_gate stays 1, pre_found stays 1 once raised, whatever the code bits are.
- R9: Two adjacent pulses, with no 0 between them, break the run. The second pulse counts as pulse one.
- R10: After rd_gate is dropped and raised again, a full new run of sixteen well-spaced pulses is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Code-bit clock, one sample per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_gate | input | 1 | Read gate; high enables the search |
| code_bit | input | 1 | Serial code bit, 1 = pulse |
| pre_found | output | 1 | Preamble-found flag |
| sync_start | output | 1 | One-cycle pulse when the flag rises |

## Verification
Two functions can collide on a single edge: completing the sixteenth pulse and clearing on a falling read gate. The bench provokes this by delivering fifteen good pulses and then presenting the sixteenth pulse with rd_gate low. The clear must win, so pre_found and sync_start stay 0 after that edge. A second collision comes from a badly spaced pulse, which both ends the old run and starts the new one. The bench judges this by checking that the flag appears only on the sixteenth pulse counted from the violating one.

// File: rtl/p3t_pkg.sv
package p3t_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_HUNT   = 3'd1,
        ST_TRACK  = 3'd2,
        ST_SYNC   = 3'd3,
        ST_LOCKED = 3'd4
    } p3t_state_e;
endpackage

// File: rtl/p3t_gap_cnt.sv
module p3t_gap_cnt #(
    parameter int SPACING = 3,
    localparam int GW = $clog2(SPACING + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [GW-1:0] zeros,
    output logic          gap_ok
);
    logic [GW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (inc && (cnt_q < GW'(SPACING - 1))) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    generate
        if (SPACING <= 1) begin : g_tight
            assign gap_ok = 1'b1;
        end else begin : g_normal
            assign gap_ok = (cnt_q == GW'(SPACING - 1));
        end
    endgenerate

    assign zeros = cnt_q;
endmodule

// File: rtl/p3t_run_cnt.sv
module p3t_run_cnt #(
    parameter int RUN_LEN = 16,
    localparam int RW = $clog2(RUN_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          load_one,
    input  logic          inc,
    output logic [RW-1:0] run,
    output logic          at_last
);
    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            run_q <= '0;
        end else if (load_one) begin
            run_q <= RW'(1);
        end else if (inc && (run_q < RW'(RUN_LEN))) begin
            run_q <= run_q + 1'b1;
        end
    end

    assign at_last = (run_q == RW'(RUN_LEN - 1));
    assign run     = run_q;
endmodule

// File: rtl/p3t_fsm.sv
module p3t_fsm
    import p3t_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_gate,
    input  logic       code_bit,
    input  logic       gap_ok,
    input  logic       at_last,
    output logic       gap_clr,
    output logic       gap_inc,
    output logic       run_clr,
    output logic       run_load,
    output logic       run_inc,
    output logic       pre_found,
    output logic       sync_start,
    output p3t_state_e state
);
    p3t_state_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d     = st_q;
        gap_clr  = 1'b0;
        gap_inc  = 1'b0;
        run_clr  = 1'b0;
        run_load = 1'b0;
        run_inc  = 1'b0;
        if (!rd_gate) begin
            st_d    = ST_IDLE;
            gap_clr = 1'b1;
            run_clr = 1'b1;
        end else begin
            unique case (st_q)
                ST_IDLE, ST_HUNT: begin
                    if (code_bit) begin
                        st_d     = ST_TRACK;
                        run_load = 1'b1;
                        gap_clr  = 1'b1;
                    end else begin
                        st_d = ST_HUNT;
                    end
                end
                ST_TRACK: begin
                    if (code_bit) begin
                        gap_clr = 1'b1;
                        if (gap_ok) begin
                            run_inc = 1'b1;
                            if (at_last) begin
                                st_d = ST_SYNC;
                            end
                        end else begin
                            run_load = 1'b1;
                        end
                    end else if (gap_ok) begin
                        st_d    = ST_HUNT;
                        run_clr = 1'b1;
                        gap_clr = 1'b1;
                    end else begin
                        gap_inc = 1'b1;
                    end
                end
                ST_SYNC: begin
                    st_d = ST_LOCKED;
                end
                ST_LOCKED: begin
                    st_d = ST_LOCKED;
                end
                default: begin
                    st_d = ST_IDLE;
                end
            endcase
        end
    end

    always_comb begin
        pre_found  = (st_q == ST_SYNC) || (st_q == ST_LOCKED);
        sync_start = (st_q == ST_SYNC);
    end

    assign state = st_q;
endmodule

// File: rtl/preamble3t_det.sv
module preamble3t_det #(
    parameter int RUN_LEN = 16,
    parameter int SPACING = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_gate,
    input  logic code_bit,
    output logic pre_found,
    output logic sync_start
);
    import p3t_pkg::*;

    localparam int GW = $clog2(SPACING + 1);
    localparam int RW = $clog2(RUN_LEN + 1);

    logic          gap_clr, gap_inc, gap_ok;
    logic          run_clr, run_load, run_inc, at_last;
    logic [GW-1:0] zeros;
    logic [RW-1:0] run;
    p3t_state_e    state;

    p3t_gap_cnt #(.SPACING(SPACING)) gap_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (gap_clr),
        .inc    (gap_inc),
        .zeros  (zeros),
        .gap_ok (gap_ok)
    );

    p3t_run_cnt #(.RUN_LEN(RUN_LEN)) run_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (run_clr),
        .load_one (run_load),
        .inc      (run_inc),
        .run      (run),
        .at_last  (at_last)
    );

    p3t_fsm fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_gate    (rd_gate),
        .code_bit   (code_bit),
        .gap_ok     (gap_ok),
        .at_last    (at_last),
        .gap_clr    (gap_clr),
        .gap_inc    (gap_inc),
        .run_clr    (run_clr),
        .run_load   (run_load),
        .run_inc    (run_inc),
        .pre_found  (pre_found),
        .sync_start (sync_start),
        .state      (state)
    );
endmodule

// File: rtl/p3t_chk.sv
module p3t_chk #(
    parameter int RUN_LEN = 16,
    parameter int SPACING = 3,
    localparam int GW = $clog2(SPACING + 1),
    localparam int RW = $clog2(RUN_LEN + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_gate,
    input logic          code_bit,
    input logic          pre_found,
    input logic          sync_start,
    input logic [GW-1:0] zeros,
    input logic [RW-1:0] run
);
    p_gate_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_gate |=> (!pre_found && !sync_start && run == '0));

    p_rise_on_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pre_found) |-> ($past(code_bit) && $past(rd_gate)));

    p_sync_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sync_start |=> !sync_start);

    p_sync_with_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pre_found) |-> sync_start);

    p_sync_implies_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sync_start |-> pre_found);

    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_found && rd_gate) |=> pre_found);

    p_run_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run <= RW'(RUN_LEN));

    p_gap_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        zeros < GW'(SPACING));
endmodule

bind preamble3t_det p3t_chk #(.RUN_LEN(RUN_LEN), .SPACING(SPACING)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_gate    (rd_gate),
    .code_bit   (code_bit),
    .pre_found  (pre_found),
    .sync_start (sync_start),
    .zeros      (zeros),
    .run        (run)
);

// File: tb/preamble3t_det_tb.sv
module preamble3t_det_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 7;
    localparam int V_N    [NVEC] = '{16, 15, 16, 16, 16, 17, 3};
    localparam int V_SP   [NVEC] = '{ 3,  3,  2,  4,  1,  3, 3};
    localparam int V_FLAG [NVEC] = '{ 1,  0,  0,  0,  0,  1, 0};
    localparam int V_SYNC [NVEC] = '{ 1,  0,  0,  0,  0,  0, 0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_gate = 1'b0;
    logic code_bit = 1'b0;
    logic pre_found, sync_start;
    int   checks = 0;
    int   errors = 0;
    int   cycles = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    preamble3t_det dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_gate    (rd_gate),
        .code_bit   (code_bit),
        .pre_found  (pre_found),
        .sync_start (sync_start)
    );

    task automatic step(input logic g, input logic b);
        rd_gate  = g;
        code_bit = b;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // n pulses, each followed by sp-1 zeros except the last
    task automatic emit(input int n, input int sp);
        for (int i = 0; i < n; i++) begin
            step(1'b1, 1'b1);
            if (i < n - 1) begin
                for (int j = 0; j < sp - 1; j++) step(1'b1, 1'b0);
            end
        end
    endtask

    task automatic idle2();
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual=expired expected=done");
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        // R1 reset
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        chk("R1 flag in reset", pre_found, 1'b0);
        chk("R1 sync in reset", sync_start, 1'b0);
        rst_n = 1'b1;
        step(1'b0, 1'b0);
        chk("R1 flag after reset", pre_found, 1'b0);
        chk("R1 sync after reset", sync_start, 1'b0);

        // table: R3 R4 R5 R6 R9
        for (int v = 0; v < NVEC; v++) begin
            idle2();
            emit(V_N[v], V_SP[v]);
            chk($sformatf("R3/R4/R5/R6/R9 vec%0d flag", v), pre_found, V_FLAG[v] != 0);
            chk($sformatf("R7 vec%0d sync", v), sync_start, V_SYNC[v] != 0);
        end

        // R5: a short-spaced pulse restarts as pulse one
        idle2();
        emit(5, 3);
        step(1'b1, 1'b0);
        emit(15, 3);
        chk("R5 15 after short pulse", pre_found, 1'b0);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        chk("R5 16th after short pulse", pre_found, 1'b1);

        // R9: adjacent pulse restarts
        idle2();
        emit(8, 3);
        emit(16, 3);
        chk("R9 adjacent pulse starts new run", pre_found, 1'b1);

        // R6: long gap clears the run
        idle2();
        emit(10, 3);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        emit(15, 3);
        chk("R6 15 after long gap", pre_found, 1'b0);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        chk("R6 16 after long gap flag", pre_found, 1'b1);
        chk("R7 sync on rise", sync_start, 1'b1);
        step(1'b1, 1'b1);
        chk("R7 sync drops", sync_start, 1'b0);
        chk("R7 flag held", pre_found, 1'b1);

        // R8: flag holds under arbitrary bits
        for (int k = 0; k < 20; k++) begin
            step(1'b1, 1'((k * 7 + 3) % 5 == 0));
            chk("R8 flag sticky", pre_found, 1'b1);
            chk("R8 no extra sync", sync_start, 1'b0);
        end

        // R2: gate drop clears, gated-off pulses ignored
        step(1'b0, 1'b1);
        chk("R2 flag cleared", pre_found, 1'b0);
        chk("R2 sync low", sync_start, 1'b0);
        for (int k = 0; k < 48; k++) step(1'b0, 1'(k % 3 == 0));
        chk("R2 gated-off pulses ignored", pre_found, 1'b0);

        // R10: after regate, full run needed
        emit(15, 3);
        chk("R10 15 after regate", pre_found, 1'b0);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        chk("R10 16 after regate", pre_found, 1'b1);

        // collision: 16th pulse arrives with gate low
        idle2();
        emit(15, 3);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b1);
        chk("R2 gate-low wins over 16th", pre_found, 1'b0);
        chk("R2 no sync on gated 16th", sync_start, 1'b0);
        emit(1, 3);
        chk("R10 run restarted after collision", pre_found, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule